// File: doc/BRIEF.md
# Display Controller Register Bank

This block is the software-visible register file of a display controller. A host reaches it over a simple single-cycle 32-bit bus that accepts whole-word accesses only. The registers it holds cover the output enables and global configuration, two background colours and two transparency keys, four timing words, a line-number word, and the frame sizes of a digital output and an LCD output. It also holds the state of one graphics layer: three base addresses, position, size, attributes, FIFO thresholds and row, column and window increments. Sizes are stored in count-minus-one form and read back in that same form.

An interrupt status word and an enable mask drive a level interrupt. Software clears status bits by writing ones to them. A companion transfer engine sets the completion bit through an event input. When software writes the idle-mode word with bit 1 set, every register returns to its reset value. A one-cycle invalidate strobe tells the rendering pipeline that state affecting the displayed image has changed. The pipeline's own enables and the layer pixel format are brought out as ports.

Top module: `dispctl_regbank`

## Requirements
- R1: An access whose byte-enable is not 4'b1111 is a bad-width access. A bad-width write changes no register and raises no invalidate. A bad-width read returns 0.
- R2: A read request (bus_req=1, bus_wr=0) gives bus_rvld=1 with its data in the following cycle, and bus_rvld=0 otherwise. Unmapped offsets (0x78 and above, or addr[1:0]!=0) read 0 and ignore writes.
- R3: The status word at 0x0C clears each bit that is written as 1 and keeps bits written as 0. A high evt_i[0] sets status bit 0 on the clock edge. If the same edge carries a write of 1 to bit 0, the bit ends up set.
- R4: irq_o is high exactly when (status AND enable) is nonzero. The enable word at 0x10 keeps only bits 15:0.
- R5: A full-width write to the idle-mode word at 0x08 with bit 1 set returns every other register, status and enable included, to its reset value. The idle-mode word then holds the written value AND 0x301B. A write to 0x08 with bit 1 clear changes no other register.
- R6: The digital-output size (0x48), LCD size (0x4C), layer size (0x5C) and layer position (0x58) keep an 11-bit field at bits 10:0 and another at bits 26:16 (write mask 0x07FF07FF). Sizes hold N-1 and read 0 after reset.
- R7: The control word at 0x14 keeps the written value AND 0x07FF9FFF. Its bit 0 drives lcd_en_o and its bit 1 drives dig_en_o.
- R8: Background colours (0x20, 0x24) and transparency keys (0x28, 0x2C) keep 24 bits. The line number (0x34) keeps 11 bits. Timing words 0x38, 0x3C, 0x40 and 0x44 use masks 0x0FF0FF3F, 0x0FF0FF3F, 0x0003FFFF and 0x00FF00FF.
- R9: Offset 0x00 reads 0x20, 0x04 reads 1 and 0x30 reads 0x7FF, whatever is written to them. The capability word at 0x1C resets to 0x161 and keeps writes AND 0x3FF.
- R10: The layer attribute word at 0x60 keeps 11 bits. Its bit 0 drives gfx_en_o and bits 4:1 drive gfx_fmt_o. The threshold word at 0x64 uses mask 0x01FF01FF.
- R11: inval_o is high for the one cycle after a full-width write to any of 0x14, 0x18, 0x20-0x2C, 0x48-0x60, 0x68, 0x6C or 0x74. Writes to other offsets leave it low.
- R12: The row increment (0x68) and column increment (0x6C) reset to 1. The window increment (0x70) resets to 0. All three, and the layer addresses at 0x50, 0x54 and 0x74, keep all 32 bits. The configuration word at 0x18 keeps 14 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvld |
| bus_rvld | output | 1 | Read data valid, one cycle after request |
| evt_i | input | EVT_W | Completion events setting low status bits |
| irq_o | output | 1 | Level interrupt |
| inval_o | output | 1 | Display-state-changed strobe |
| lcd_en_o | output | 1 | LCD output enable |
| dig_en_o | output | 1 | Digital output enable |
| gfx_en_o | output | 1 | Graphics layer enable |
| gfx_fmt_o | output | 4 | Graphics layer pixel format |

## Verification
A wrong stored value shows up on bus_rdata one cycle after the next read of its offset. For the control and attribute words it also shows up on the enable and format ports right after the write edge. A broken status or enable path shows on irq_o on the edge that follows the event, clear or mask write, and a missed or spurious strobe shows on inval_o one cycle after the write. A soft reset that misses a register stays hidden until that register is read back, so the bench reads a set of differently shaped registers after the reset.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  localparam int DATA_W = 32;
  localparam int NREG   = 30;
  localparam int SZ_W   = 11;
  localparam int COL_W  = 24;

  localparam logic [DATA_W-1:0] FLD_M   = DATA_W'((64'd1 << SZ_W) - 1);
  localparam logic [DATA_W-1:0] PAIR_M  = FLD_M | (FLD_M << 16);
  localparam logic [DATA_W-1:0] COL_M   = DATA_W'((64'd1 << COL_W) - 1);
  localparam logic [DATA_W-1:0] FULL_M  = '1;

  // word indexes (byte offset = 4 * index)
  localparam int IX_REV   = 0;
  localparam int IX_SYSST = 1;
  localparam int IX_IDLE  = 2;
  localparam int IX_ISTAT = 3;
  localparam int IX_IEN   = 4;
  localparam int IX_CTRL  = 5;
  localparam int IX_CFG   = 6;
  localparam int IX_CAPS  = 7;
  localparam int IX_BG0   = 8;
  localparam int IX_BG1   = 9;
  localparam int IX_KEY0  = 10;
  localparam int IX_KEY1  = 11;
  localparam int IX_LSTAT = 12;
  localparam int IX_LINE  = 13;
  localparam int IX_TIM0  = 14;
  localparam int IX_TIM1  = 15;
  localparam int IX_TIM2  = 16;
  localparam int IX_TIM3  = 17;
  localparam int IX_DSZ   = 18;
  localparam int IX_LSZ   = 19;
  localparam int IX_GA0   = 20;
  localparam int IX_GA1   = 21;
  localparam int IX_GPOS  = 22;
  localparam int IX_GSZ   = 23;
  localparam int IX_GATTR = 24;
  localparam int IX_GTHR  = 25;
  localparam int IX_ROWI  = 26;
  localparam int IX_COLI  = 27;
  localparam int IX_WINI  = 28;
  localparam int IX_GA2   = 29;

  typedef enum logic [1:0] {K_NONE, K_RO, K_RW, K_IRQ} reg_kind_e;

  function automatic reg_kind_e reg_kind(int i);
    case (i)
      IX_REV, IX_SYSST, IX_LSTAT: return K_RO;
      IX_ISTAT, IX_IEN:           return K_IRQ;
      default:                    return (i < NREG) ? K_RW : K_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_mask(int i);
    case (i)
      IX_IDLE:                         return 32'h0000_301B;
      IX_CTRL:                         return 32'h07FF_9FFF;
      IX_CFG:                          return 32'h0000_3FFF;
      IX_CAPS:                         return 32'h0000_03FF;
      IX_BG0, IX_BG1, IX_KEY0, IX_KEY1: return COL_M;
      IX_LINE:                         return FLD_M;
      IX_TIM0, IX_TIM1:                return 32'h0FF0_FF3F;
      IX_TIM2:                         return 32'h0003_FFFF;
      IX_TIM3:                         return 32'h00FF_00FF;
      IX_DSZ, IX_LSZ, IX_GPOS, IX_GSZ: return PAIR_M;
      IX_GATTR:                        return FLD_M;
      IX_GTHR:                         return 32'h01FF_01FF;
      default:                         return FULL_M;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_rst(int i);
    case (i)
      IX_CAPS:          return 32'h0000_0161;
      IX_ROWI, IX_COLI: return 32'h0000_0001;
      default:          return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] ro_val(int i);
    case (i)
      IX_REV:   return 32'h0000_0020;
      IX_SYSST: return 32'h0000_0001;
      IX_LSTAT: return FLD_M;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [NREG-1:0] inval_vec();
    logic [NREG-1:0] v;
    v = '0;
    for (int i = 0; i < NREG; i++) begin
      case (i)
        IX_CTRL, IX_CFG, IX_BG0, IX_BG1, IX_KEY0, IX_KEY1,
        IX_DSZ, IX_LSZ, IX_GA0, IX_GA1, IX_GPOS, IX_GSZ,
        IX_GATTR, IX_ROWI, IX_COLI, IX_GA2: v[i] = 1'b1;
        default:                           v[i] = 1'b0;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/dispctl_rst_sync.sv
module dispctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dispctl_decode.sv
module dispctl_decode
  import dispctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic              wdata_srst_bit,
  output logic [NREG-1:0]   wr_vec,
  output logic [NREG-1:0]   rd_vec,
  output logic              rd_en,
  output logic              srst_req,
  output logic              inval_req
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [NREG-1:0] INV_SEL = inval_vec();

  logic [IDX_W-1:0] idx;
  logic             full_w;
  logic             aligned;
  logic             wr_ok;
  logic             rd_ok;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign full_w  = (bus_be == 4'hF);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign rd_en   = bus_req && !bus_wr;
  assign wr_ok   = bus_req && bus_wr && full_w && aligned;
  assign rd_ok   = rd_en && full_w && aligned;

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_vec[g] = wr_ok && (idx == IDX_W'(g));
    assign rd_vec[g] = rd_ok && (idx == IDX_W'(g));
  end

  assign srst_req  = wr_vec[IX_IDLE] && wdata_srst_bit;
  assign inval_req = |(wr_vec & INV_SEL);

endmodule

// File: rtl/dispctl_word.sv
module dispctl_word #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    MASK = '1,
  parameter logic [W-1:0]    RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         srst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we)        q_nxt = d & MASK;
    else if (srst) q_nxt = RSTV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RSTV;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/dispctl_irq.sv
module dispctl_irq #(
  parameter int IRQ_W = 16,
  parameter int EVT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_we,
  input  logic             en_we,
  input  logic             srst,
  input  logic [IRQ_W-1:0] wdata,
  input  logic [EVT_W-1:0] evt,
  output logic [IRQ_W-1:0] stat_q,
  output logic [IRQ_W-1:0] en_q,
  output logic             irq
);

  logic [IRQ_W-1:0] stat_nxt;
  logic [IRQ_W-1:0] en_nxt;

  always_comb begin
    stat_nxt = stat_q;
    if (srst)    stat_nxt = '0;
    if (stat_we) stat_nxt = stat_nxt & ~wdata;
    stat_nxt[EVT_W-1:0] = stat_nxt[EVT_W-1:0] | evt;
  end

  always_comb begin
    en_nxt = en_q;
    if (en_we)     en_nxt = wdata;
    else if (srst) en_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_nxt;
      en_q   <= en_nxt;
    end
  end

  assign irq = |(stat_q & en_q);

endmodule

// File: rtl/dispctl_regbank.sv
module dispctl_regbank
  import dispctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IRQ_W  = 16,
  parameter int EVT_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvld,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              irq_o,
  output logic              inval_o,
  output logic              lcd_en_o,
  output logic              dig_en_o,
  output logic              gfx_en_o,
  output logic [3:0]        gfx_fmt_o
);

  logic                rst_sync_n;
  logic [NREG-1:0]     wr_vec;
  logic [NREG-1:0]     rd_vec;
  logic                rd_en;
  logic                srst_req;
  logic                inval_req;
  logic [IRQ_W-1:0]    stat_w;
  logic [IRQ_W-1:0]    en_w;
  logic [DATA_W-1:0]   view [NREG];
  logic [DATA_W-1:0]   rd_val;
  logic [DATA_W-1:0]   rdata_q, rdata_nxt;
  logic                rvld_q, rvld_nxt;
  logic                inval_q, inval_nxt;

  dispctl_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dispctl_decode #(.ADDR_W(ADDR_W)) i_decode (
    .bus_req        (bus_req),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_be         (bus_be),
    .wdata_srst_bit (bus_wdata[1]),
    .wr_vec         (wr_vec),
    .rd_vec         (rd_vec),
    .rd_en          (rd_en),
    .srst_req       (srst_req),
    .inval_req      (inval_req)
  );

  dispctl_irq #(.IRQ_W(IRQ_W), .EVT_W(EVT_W)) i_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .stat_we (wr_vec[IX_ISTAT]),
    .en_we   (wr_vec[IX_IEN]),
    .srst    (srst_req),
    .wdata   (bus_wdata[IRQ_W-1:0]),
    .evt     (evt_i),
    .stat_q  (stat_w),
    .en_q    (en_w),
    .irq     (irq_o)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_word
    if (reg_kind(g) == K_RW) begin : g_rw
      dispctl_word #(
        .W    (DATA_W),
        .MASK (reg_mask(g)),
        .RSTV (reg_rst(g))
      ) i_word (
        .clk  (clk),
        .rst_n(rst_sync_n),
        .we   (wr_vec[g]),
        .srst (srst_req),
        .d    (bus_wdata),
        .q    (view[g])
      );
    end else if (reg_kind(g) == K_RO) begin : g_ro
      assign view[g] = ro_val(g);
    end else if (g == IX_ISTAT) begin : g_stat
      assign view[g] = DATA_W'(stat_w);
    end else begin : g_en
      assign view[g] = DATA_W'(en_w);
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_vec[i]) rd_val = rd_val | view[i];
    end
  end

  always_comb begin
    rdata_nxt = rdata_q;
    if (rd_en) rdata_nxt = rd_val;
    rvld_nxt  = rd_en;
    inval_nxt = inval_req;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      rdata_q <= rdata_nxt;
      rvld_q  <= rvld_nxt;
      inval_q <= inval_nxt;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_rvld  = rvld_q;
  assign inval_o   = inval_q;
  assign lcd_en_o  = view[IX_CTRL][0];
  assign dig_en_o  = view[IX_CTRL][1];
  assign gfx_en_o  = view[IX_GATTR][0];
  assign gfx_fmt_o = view[IX_GATTR][4:1];

endmodule

// File: rtl/dispctl_regbank_chk.sv
module dispctl_regbank_chk
  import dispctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IRQ_W  = 16,
  parameter int EVT_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvld,
  input logic [EVT_W-1:0]  evt_i,
  input logic [IRQ_W-1:0]  stat_q,
  input logic              irq_o,
  input logic              inval_o,
  input logic              lcd_en_o,
  input logic              gfx_en_o
);

  localparam logic [ADDR_W-1:0] OFF_IEN  = ADDR_W'(IX_IEN * 4);
  localparam logic [ADDR_W-1:0] OFF_IDLE = ADDR_W'(IX_IDLE * 4);

  logic full_wr;
  assign full_wr = bus_req && bus_wr && (bus_be == 4'hF);

  // R2
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |=> bus_rvld);

  // R2
  no_spur_rvld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_wr) |=> !bus_rvld);

  // R1
  badw_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_be != 4'hF) |=> (bus_rdata == 32'h0));

  // R1
  badw_no_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_be != 4'hF) |=> !inval_o);

  // R3
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[0] |=> stat_q[0]);

  // R4
  ien_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && bus_addr == OFF_IEN && bus_wdata[IRQ_W-1:0] == '0) |=> !irq_o);

  // R5
  srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && bus_addr == OFF_IDLE && bus_wdata[1]) |=> (!lcd_en_o && !gfx_en_o && !irq_o));

  // R11
  inval_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_o |-> $past(full_wr));

endmodule

bind dispctl_regbank dispctl_regbank_chk #(
  .ADDR_W (ADDR_W),
  .IRQ_W  (IRQ_W),
  .EVT_W  (EVT_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_req   (bus_req),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvld  (bus_rvld),
  .evt_i     (evt_i),
  .stat_q    (stat_w),
  .irq_o     (irq_o),
  .inval_o   (inval_o),
  .lcd_en_o  (lcd_en_o),
  .gfx_en_o  (gfx_en_o)
);

// File: tb/test_dispctl_regbank.sv
module test_dispctl_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  localparam logic [7:0] A_REV = 8'h00, A_SYS = 8'h04, A_IDLE = 8'h08, A_STAT = 8'h0C,
                         A_IEN = 8'h10, A_CTRL = 8'h14, A_CFG = 8'h18, A_CAPS = 8'h1C,
                         A_BG0 = 8'h20, A_KEY1 = 8'h2C, A_LST = 8'h30, A_LINE = 8'h34,
                         A_TIM0 = 8'h38, A_TIM1 = 8'h3C, A_TIM2 = 8'h40, A_TIM3 = 8'h44,
                         A_DSZ = 8'h48, A_LSZ = 8'h4C, A_GA0 = 8'h50, A_GPOS = 8'h58,
                         A_GSZ = 8'h5C, A_ATTR = 8'h60, A_THR = 8'h64, A_ROWI = 8'h68,
                         A_COLI = 8'h6C, A_WINI = 8'h70, A_GA2 = 8'h74;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_wr;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvld;
  logic [0:0]  evt_i;
  logic        irq_o, inval_o, lcd_en_o, dig_en_o, gfx_en_o;
  logic [3:0]  gfx_fmt_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dispctl_regbank #(.ADDR_W(ADDR_W), .IRQ_W(16), .EVT_W(1)) i_dispctl_regbank (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvld(bus_rvld),
    .evt_i(evt_i), .irq_o(irq_o), .inval_o(inval_o), .lcd_en_o(lcd_en_o),
    .dig_en_o(dig_en_o), .gfx_en_o(gfx_en_o), .gfx_fmt_o(gfx_fmt_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (!done && rst_n && bus_rvld) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R2 unexpected response: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          miscompares++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  // one access; entered and left at a falling edge
  task automatic acc(logic wr, logic [7:0] a, logic [31:0] d, logic [3:0] be, logic ev);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_be = be; evt_i = ev;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; bus_be = 4'h0; evt_i = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    acc(1'b1, a, d, 4'hF, 1'b0);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    acc(1'b0, a, 32'h0, 4'hF, 1'b0);
  endtask

  task automatic pulse_evt();
    evt_i = 1'b1;
    @(negedge clk);
    evt_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0;
    bus_wdata = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk("R4 reset irq", {31'b0, irq_o}, 32'h0);
    chk("R11 reset inval", {31'b0, inval_o}, 32'h0);
    chk("R7 reset enables", {30'b0, dig_en_o, lcd_en_o}, 32'h0);
    chk("R10 reset layer", {27'b0, gfx_fmt_o, gfx_en_o}, 32'h0);
    chk("R2 reset rvld", {31'b0, bus_rvld}, 32'h0);

    // R9 fixed and capability values
    rd(A_REV, 32'h20, "R9 revision");
    rd(A_SYS, 32'h1, "R9 reset-done");
    rd(A_LST, 32'h7FF, "R9 line status");
    rd(A_CAPS, 32'h161, "R9 caps reset");
    wr(A_REV, 32'hFFFF_FFFF);
    rd(A_REV, 32'h20, "R9 revision after write");
    wr(A_CAPS, 32'hFFFF_FFFF);
    rd(A_CAPS, 32'h3FF, "R9 caps mask");

    // R6 / R12 reset values
    rd(A_DSZ, 32'h0, "R6 digital size reset");
    rd(A_GSZ, 32'h0, "R6 layer size reset");
    rd(A_ROWI, 32'h1, "R12 row inc reset");
    rd(A_COLI, 32'h1, "R12 col inc reset");
    rd(A_WINI, 32'h0, "R12 window inc reset");

    // R7 control
    wr(A_CTRL, 32'hFFFF_FFFF);
    chk("R11 inval after control", {31'b0, inval_o}, 32'h1);
    chk("R7 both enables", {30'b0, dig_en_o, lcd_en_o}, 32'h3);
    rd(A_CTRL, 32'h07FF_9FFF, "R7 control mask");
    wr(A_CTRL, 32'h2);
    chk("R7 digital only", {30'b0, dig_en_o, lcd_en_o}, 32'h2);
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, 32'h3FFF, "R12 config mask");

    // R8 colours, line and timing
    wr(A_BG0, 32'hFFFF_FFFF);
    chk("R11 inval after background", {31'b0, inval_o}, 32'h1);
    rd(A_BG0, 32'h00FF_FFFF, "R8 background");
    wr(A_KEY1, 32'hAB12_3456);
    rd(A_KEY1, 32'h0012_3456, "R8 key");
    wr(A_LINE, 32'hFFFF);
    chk("R11 no inval after line", {31'b0, inval_o}, 32'h0);
    rd(A_LINE, 32'h7FF, "R8 line");
    wr(A_TIM0, 32'hFFFF_FFFF); rd(A_TIM0, 32'h0FF0_FF3F, "R8 timing0");
    wr(A_TIM1, 32'hFFFF_FFFF); rd(A_TIM1, 32'h0FF0_FF3F, "R8 timing1");
    wr(A_TIM2, 32'hFFFF_FFFF); rd(A_TIM2, 32'h0003_FFFF, "R8 timing2");
    wr(A_TIM3, 32'hFFFF_FFFF); rd(A_TIM3, 32'h00FF_00FF, "R8 timing3");

    // R6 sizes and position
    wr(A_DSZ, 32'hFFFF_FFFF);
    chk("R11 inval after size", {31'b0, inval_o}, 32'h1);
    rd(A_DSZ, 32'h07FF_07FF, "R6 digital size mask");
    wr(A_LSZ, 32'h0123_0456); rd(A_LSZ, 32'h0123_0456, "R6 lcd size");
    wr(A_GPOS, 32'hF8AA_F955); rd(A_GPOS, 32'h00AA_0155, "R6 position");

    // R10 attributes and threshold
    wr(A_ATTR, 32'h0000_FFFF);
    chk("R10 layer en/fmt all", {27'b0, gfx_fmt_o, gfx_en_o}, 32'h1F);
    rd(A_ATTR, 32'h7FF, "R10 attr mask");
    wr(A_ATTR, 32'h0000_000B);
    chk("R10 layer fmt 5", {27'b0, gfx_fmt_o, gfx_en_o}, 32'h0B);
    wr(A_THR, 32'hFFFF_FFFF);
    chk("R11 no inval after threshold", {31'b0, inval_o}, 32'h0);
    rd(A_THR, 32'h01FF_01FF, "R10 threshold mask");

    // R12 full-width increments and addresses
    wr(A_ROWI, 32'hDEAD_BEEF);
    chk("R11 inval after row inc", {31'b0, inval_o}, 32'h1);
    rd(A_ROWI, 32'hDEAD_BEEF, "R12 row inc");
    wr(A_WINI, 32'h8000_0001);
    chk("R11 no inval after window inc", {31'b0, inval_o}, 32'h0);
    rd(A_WINI, 32'h8000_0001, "R12 window inc");
    wr(A_GA2, 32'h1234_5678); rd(A_GA2, 32'h1234_5678, "R12 address 2");

    // R1 bad width
    acc(1'b1, A_CTRL, 32'h0, 4'h3, 1'b0);
    chk("R1 no inval on bad write", {31'b0, inval_o}, 32'h0);
    chk("R1 control kept", {30'b0, dig_en_o, lcd_en_o}, 32'h2);
    exp_q.push_back(32'h0); tag_q.push_back("R1 bad-width read");
    acc(1'b0, A_CTRL, 32'h0, 4'h7, 1'b0);
    rd(A_CTRL, 32'h2, "R1 control after bad write");

    // R2 unmapped and unaligned
    rd(8'h78, 32'h0, "R2 unmapped");
    rd(8'hFC, 32'h0, "R2 top unmapped");
    wr(8'h15, 32'h1);
    rd(A_CTRL, 32'h2, "R2 unaligned write ignored");

    // R3 / R4 interrupt behaviour
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, 32'h0000_FFFF, "R4 enable width");
    chk("R4 no status no irq", {31'b0, irq_o}, 32'h0);
    pulse_evt();
    chk("R3 event raises irq", {31'b0, irq_o}, 32'h1);
    rd(A_STAT, 32'h1, "R3 status set");
    wr(A_STAT, 32'hFFFF_FFFE);
    chk("R3 write zero keeps bit", {31'b0, irq_o}, 32'h1);
    wr(A_STAT, 32'h1);
    chk("R3 write one clears", {31'b0, irq_o}, 32'h0);
    rd(A_STAT, 32'h0, "R3 status cleared");
    acc(1'b1, A_STAT, 32'h1, 4'hF, 1'b1);
    chk("R3 set wins over clear", {31'b0, irq_o}, 32'h1);
    wr(A_IEN, 32'h0);
    chk("R4 masked", {31'b0, irq_o}, 32'h0);
    rd(A_STAT, 32'h1, "R4 status kept while masked");
    wr(A_IEN, 32'h1);
    chk("R4 unmasked", {31'b0, irq_o}, 32'h1);

    // R5 soft reset
    wr(A_CTRL, 32'h3);
    wr(A_IDLE, 32'h1);
    chk("R5 idle write without reset bit", {30'b0, dig_en_o, lcd_en_o}, 32'h3);
    rd(A_IDLE, 32'h1, "R5 idle value");
    wr(A_IDLE, 32'hFFFF_FFFF);
    chk("R5 irq after soft reset", {31'b0, irq_o}, 32'h0);
    chk("R5 enables after soft reset", {30'b0, dig_en_o, lcd_en_o}, 32'h0);
    chk("R5 layer after soft reset", {27'b0, gfx_fmt_o, gfx_en_o}, 32'h0);
    rd(A_IDLE, 32'h301B, "R5 idle mask");
    rd(A_CTRL, 32'h0, "R5 control reset");
    rd(A_IEN, 32'h0, "R5 enable reset");
    rd(A_STAT, 32'h0, "R5 status reset");
    rd(A_CAPS, 32'h161, "R5 caps reset");
    rd(A_ROWI, 32'h1, "R5 row inc reset");
    rd(A_BG0, 32'h0, "R5 background reset");
    rd(A_DSZ, 32'h0, "R5 size reset");
    rd(A_GA2, 32'h0, "R5 address reset");

    repeat (3) @(negedge clk);
    vectors++;
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R2 missing responses: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule